// File: doc/BRIEF.md
# Virtual Interval Timer

This block gives one processor a timer that runs in guest time. A host cycle counter comes in as an input. The block adds a programmable offset to that count and presents the result as the guest counter. It also keeps a floor value, which is the last time the guest is known to have reached. The counter it shows never drops below that floor, so the guest never sees time jump back past the point where the timer last went off.

A match register arms a one-shot expiry. When the guest counter reaches the match value, the block produces a one-cycle interrupt request carrying the 8-bit code held in the vector register. If the vector register is masked at that moment, the expiry is held in a pending flag instead. The request is then issued when software unmasks the register. Arming a new match also produces a one-cycle withdraw strobe carrying the current code, so the neighbouring interrupt controller can drop a stale request. All three registers are written and read through a single select-addressed port.

Top module: `vit_timer`

## Requirements
- R1: The counter read (select 0) returns host_cnt plus the stored offset when that sum is at least the floor value; otherwise it returns the floor.
- R2: A counter write (select 0) makes the counter read return the written value on the next cycle (host unchanged) and clears the floor to 0.
- R3: After reset, the counter reads 0, the match (select 1) reads 0, the vector register (select 2) reads 0x10000, and no strobe is active.
- R4: When an armed timer sees the guest counter at or above the match while the vector register is unmasked, irq_valid is high for exactly one cycle, on the cycle after that condition, with irq_vec equal to vector bits [7:0]. The timer then disarms.
- R5: An expiry while the mask (vector bit 16) is set produces no request and sets a pending flag. A later vector write with bit 16 clear raises irq_valid on the next cycle with the newly written code and clears the flag, so a repeated unmasking write raises nothing.
- R6: On expiry the floor becomes match + 1, so the counter reads at least match + 1 even if the host count falls back.
- R7: A match write whose value is not above the floor disarms the timer, and no request follows.
- R8: A match write above the floor but already at or below the guest counter fires on the first cycle with no register write, so irq_valid appears two cycles after the write.
- R9: A match write above the floor raises cancel_valid on the next cycle with cancel_vec equal to the current vector code; a match write that does not arm raises no cancel.
- R10: A counter write at or above the armed match disarms the timer without a request. A counter write below the match keeps it armed.
- R11: The vector register stores only bit 16 (mask) and bits [7:0] (code); other bits read back 0. An unmasking write with nothing pending raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cnt | input | CNT_W | Host cycle counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 match, 2 vector, 3 none |
| wr_data | input | CNT_W | Write value |
| rd_sel | input | 2 | Read source, same encoding |
| rd_data | output | CNT_W | Combinational read value (0 for select 3) |
| irq_valid | output | 1 | One-cycle timer interrupt request |
| irq_vec | output | 8 | Interrupt code for irq_valid |
| cancel_valid | output | 1 | One-cycle withdraw strobe on arming |
| cancel_vec | output | 8 | Code to withdraw |

## Verification
The bench moves the host count backward just after an expiry. A design without the match + 1 floor would show the guest a counter below the time it already observed. A stale match equal to the floor, and a counter write past an armed match, both test against spurious firing: a design that compared with the wrong relation would raise a request. A masked expiry followed by two unmasking writes catches a pending flag that is never cleared, which would deliver a duplicate request, or that is dropped, which would lose the interrupt. A match set behind the current time checks that the timer fires at once rather than waiting for the counter to wrap.

// File: rtl/vit_pkg.sv
package vit_pkg;

    localparam int VEC_W    = 8;
    localparam int MASK_POS = 16;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_MATCH  = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_NONE   = 2'd3
    } vit_sel_e;

    typedef struct packed {
        logic             masked;
        logic [VEC_W-1:0] code;
    } vit_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] code;
    } vit_evt_t;

    localparam vit_cfg_t CFG_RESET = '{masked: 1'b1, code: '0};
    localparam vit_evt_t EVT_IDLE  = '{valid: 1'b0, code: '0};

    function automatic logic [MASK_POS:0] cfg_image(input vit_cfg_t c);
        logic [MASK_POS:0] r;
        r = '0;
        r[MASK_POS]    = c.masked;
        r[VEC_W-1:0]   = c.code;
        return r;
    endfunction

endpackage

// File: rtl/vit_guest_clock.sv
module vit_guest_clock #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] host_cnt,
    input  logic             set_en,
    input  logic [CNT_W-1:0] set_val,
    input  logic             exp_en,
    input  logic [CNT_W-1:0] exp_floor,
    output logic [CNT_W-1:0] guest,
    output logic [CNT_W-1:0] floor_q
);
    logic [CNT_W-1:0] offset_q;
    logic [CNT_W-1:0] raw;

    always_comb begin
        raw   = host_cnt + offset_q;
        guest = (raw >= floor_q) ? raw : floor_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            offset_q <= '0 - host_cnt;
            floor_q  <= '0;
        end else if (set_en) begin
            offset_q <= set_val - host_cnt;
            floor_q  <= '0;
        end else if (exp_en) begin
            floor_q  <= exp_floor;
        end
    end
endmodule

// File: rtl/vit_match_unit.sv
module vit_match_unit #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any_wr,
    input  logic             match_wr,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] floor_val,
    input  logic [CNT_W-1:0] guest,
    output logic [CNT_W-1:0] match_q,
    output logic             armed_q,
    output logic             expire,
    output logic             arm_pulse,
    output logic [CNT_W-1:0] exp_floor
);
    always_comb begin
        arm_pulse = match_wr && (wdata > floor_val);
        expire    = armed_q && !any_wr && (guest >= match_q);
        exp_floor = match_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            armed_q <= 1'b0;
        end else if (match_wr) begin
            match_q <= wdata;
            armed_q <= arm_pulse;
        end else if (cnt_wr) begin
            if (armed_q && (wdata >= match_q))
                armed_q <= 1'b0;
        end else if (expire) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/vit_vector_unit.sv
module vit_vector_unit
    import vit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vec_wr,
    input  logic             wr_mask,
    input  logic [VEC_W-1:0] wr_code,
    input  logic             expire,
    input  logic             arm_pulse,
    output vit_cfg_t         cfg_q,
    output logic             pending_q,
    output vit_evt_t         irq_q,
    output vit_evt_t         cancel_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            pending_q <= 1'b0;
            irq_q     <= EVT_IDLE;
            cancel_q  <= EVT_IDLE;
        end else begin
            irq_q.valid    <= 1'b0;
            cancel_q.valid <= 1'b0;
            if (vec_wr) begin
                cfg_q.masked <= wr_mask;
                cfg_q.code   <= wr_code;
                if (!wr_mask && pending_q) begin
                    irq_q     <= '{valid: 1'b1, code: wr_code};
                    pending_q <= 1'b0;
                end
            end
            if (expire) begin
                if (cfg_q.masked)
                    pending_q <= 1'b1;
                else
                    irq_q <= '{valid: 1'b1, code: cfg_q.code};
            end
            if (arm_pulse)
                cancel_q <= '{valid: 1'b1, code: cfg_q.code};
        end
    end
endmodule

// File: rtl/vit_timer.sv
module vit_timer
    import vit_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] host_cnt,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vec,
    output logic             cancel_valid,
    output logic [VEC_W-1:0] cancel_vec
);
    localparam int PAD_W = CNT_W - MASK_POS - 1;

    vit_sel_e         wsel, rsel;
    logic             cnt_wr, match_wr, vec_wr;
    logic [CNT_W-1:0] guest, floor_q, match_q, exp_floor;
    logic             armed_q, expire, arm_pulse, pending_q;
    vit_cfg_t         cfg_q;
    vit_evt_t         irq_q, cancel_q;

    always_comb begin
        wsel     = vit_sel_e'(wr_sel);
        rsel     = vit_sel_e'(rd_sel);
        cnt_wr   = wr_en && (wsel == SEL_COUNT);
        match_wr = wr_en && (wsel == SEL_MATCH);
        vec_wr   = wr_en && (wsel == SEL_VECTOR);
    end

    vit_guest_clock #(.CNT_W(CNT_W)) u_clock (
        .clk      (clk),
        .rst      (rst),
        .host_cnt (host_cnt),
        .set_en   (cnt_wr),
        .set_val  (wr_data),
        .exp_en   (expire),
        .exp_floor(exp_floor),
        .guest    (guest),
        .floor_q  (floor_q)
    );

    vit_match_unit #(.CNT_W(CNT_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .any_wr   (wr_en),
        .match_wr (match_wr),
        .cnt_wr   (cnt_wr),
        .wdata    (wr_data),
        .floor_val(floor_q),
        .guest    (guest),
        .match_q  (match_q),
        .armed_q  (armed_q),
        .expire   (expire),
        .arm_pulse(arm_pulse),
        .exp_floor(exp_floor)
    );

    vit_vector_unit u_vector (
        .clk      (clk),
        .rst      (rst),
        .vec_wr   (vec_wr),
        .wr_mask  (wr_data[MASK_POS]),
        .wr_code  (wr_data[VEC_W-1:0]),
        .expire   (expire),
        .arm_pulse(arm_pulse),
        .cfg_q    (cfg_q),
        .pending_q(pending_q),
        .irq_q    (irq_q),
        .cancel_q (cancel_q)
    );

    always_comb begin
        unique case (rsel)
            SEL_COUNT:  rd_data = guest;
            SEL_MATCH:  rd_data = match_q;
            SEL_VECTOR: rd_data = {{PAD_W{1'b0}}, cfg_image(cfg_q)};
            default:    rd_data = '0;
        endcase
        irq_valid    = irq_q.valid;
        irq_vec      = irq_q.code;
        cancel_valid = cancel_q.valid;
        cancel_vec   = cancel_q.code;
    end
endmodule

// File: rtl/vit_timer_chk.sv
module vit_timer_chk
    import vit_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] guest,
    input logic [CNT_W-1:0] floor_q,
    input logic [CNT_W-1:0] match_q,
    input logic             armed_q,
    input logic             expire,
    input logic             pending_q,
    input vit_cfg_t         cfg_q,
    input logic             irq_valid,
    input logic             cancel_valid
);
    logic vec_unmask_wr, match_wr, cnt_wr;
    always_comb begin
        vec_unmask_wr = wr_en && (wr_sel == 2'd2) && !wr_data[MASK_POS];
        match_wr      = wr_en && (wr_sel == 2'd1);
        cnt_wr        = wr_en && (wr_sel == 2'd0);
    end

    assert_reset_state_R3: assert property (@(posedge clk)
        rst |=> (cfg_q.masked && match_q == '0 && !armed_q && !pending_q && !irq_valid));

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ($past(expire && !cfg_q.masked) || $past(vec_unmask_wr && pending_q)));

    assert_pending_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (vec_unmask_wr && pending_q) |=> !pending_q);

    assert_floor_after_expiry_R6: assert property (@(posedge clk) disable iff (rst)
        expire |=> (guest >= $past(match_q) + CNT_W'(1)));

    assert_stale_match_disarm_R7: assert property (@(posedge clk) disable iff (rst)
        (match_wr && wr_data <= floor_q) |=> !armed_q);

    assert_cancel_cause_R9: assert property (@(posedge clk) disable iff (rst)
        cancel_valid |-> $past(match_wr && wr_data > floor_q));

    assert_cnt_disarm_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr && armed_q && wr_data >= match_q) |=> !armed_q);
endmodule

bind vit_timer vit_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .guest       (guest),
    .floor_q     (floor_q),
    .match_q     (match_q),
    .armed_q     (armed_q),
    .expire      (expire),
    .pending_q   (pending_q),
    .cfg_q       (cfg_q),
    .irq_valid   (irq_valid),
    .cancel_valid(cancel_valid)
);

// File: tb/vit_timer_tb.sv
`timescale 1ns/1ps
module vit_timer_tb;
    localparam int CNT_W = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] host_cnt = 64'd1000;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_sel = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [1:0]       rd_sel = 2'd0;
    logic [CNT_W-1:0] rd_data;
    logic             irq_valid;
    logic [7:0]       irq_vec;
    logic             cancel_valid;
    logic [7:0]       cancel_vec;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    vit_timer #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .host_cnt(host_cnt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vec(irq_vec),
        .cancel_valid(cancel_valid), .cancel_vec(cancel_vec)
    );

    task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [CNT_W-1:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic set_host(input logic [CNT_W-1:0] h);
        host_cnt = h;
        #1;
    endtask

    task automatic t_reset_R3();
        logic [CNT_W-1:0] v;
        rd(2'd0, v); check("R3 counter", v, 0);
        rd(2'd1, v); check("R3 match", v, 0);
        rd(2'd2, v); check("R3 vector", v, 64'h10000);
        check("R3 irq", irq_valid, 0);
        check("R3 cancel", cancel_valid, 0);
    endtask

    task automatic t_count_write_R2();
        logic [CNT_W-1:0] v;
        wr(2'd0, 64'd500);
        rd(2'd0, v); check("R2 counter write", v, 500);
        set_host(64'd1010);
        rd(2'd0, v); check("R1 counter tracks host", v, 510);
    endtask

    task automatic t_fire_R4();
        wr(2'd2, 64'h42);
        check("R11 unmask no pending", irq_valid, 0);
        wr(2'd1, 64'd600);
        check("R9 cancel on arm", cancel_valid, 1);
        check("R9 cancel code", cancel_vec, 8'h42);
        step();
        check("R4 no early fire", irq_valid, 0);
        set_host(64'd1100);
        step();
        check("R4 irq strobe", irq_valid, 1);
        check("R4 irq code", irq_vec, 8'h42);
        step();
        check("R4 single cycle", irq_valid, 0);
        step();
        check("R4 disarmed after fire", irq_valid, 0);
    endtask

    task automatic t_clamp_R6();
        logic [CNT_W-1:0] v;
        set_host(64'd1095);
        rd(2'd0, v); check("R6 floor match+1", v, 601);
        set_host(64'd1110);
        rd(2'd0, v); check("R1 above floor", v, 610);
    endtask

    task automatic t_stale_match_R7();
        logic [CNT_W-1:0] v;
        wr(2'd1, 64'd601);
        check("R9 no cancel when not armed", cancel_valid, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R7 stale match silent", irq_valid, 0);
        end
        rd(2'd1, v); check("R7 match stored", v, 601);
    endtask

    task automatic t_past_match_R8();
        wr(2'd1, 64'd605);
        check("R8 cancel on arm", cancel_valid, 1);
        check("R8 not at write", irq_valid, 0);
        step();
        check("R8 immediate fire", irq_valid, 1);
        check("R8 code", irq_vec, 8'h42);
    endtask

    task automatic t_masked_R5();
        logic [CNT_W-1:0] v;
        wr(2'd2, 64'h10055);
        wr(2'd1, 64'd700);
        check("R9 cancel code masked", cancel_vec, 8'h55);
        set_host(64'd1200);
        step();
        check("R5 masked no irq", irq_valid, 0);
        step();
        check("R5 masked no irq later", irq_valid, 0);
        rd(2'd2, v); check("R5 vector readback", v, 64'h10055);
        wr(2'd2, 64'h77);
        check("R5 unmask delivers", irq_valid, 1);
        check("R5 unmask code", irq_vec, 8'h77);
        step();
        check("R5 one cycle", irq_valid, 0);
        wr(2'd2, 64'h77);
        check("R5 pending cleared", irq_valid, 0);
    endtask

    task automatic t_vec_fields_R11();
        logic [CNT_W-1:0] v;
        wr(2'd2, 64'h0000_ABCE_0012);
        rd(2'd2, v); check("R11 unmasked fields", v, 64'h12);
        check("R11 no irq", irq_valid, 0);
        wr(2'd2, 64'h0000_0003_0134);
        rd(2'd2, v); check("R11 masked fields", v, 64'h10034);
        wr(2'd2, 64'h21);
    endtask

    task automatic t_cnt_disarm_R10();
        logic [CNT_W-1:0] v;
        wr(2'd1, 64'd900);
        check("R10 armed cancel", cancel_valid, 1);
        wr(2'd0, 64'd905);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R10 disarmed by counter", irq_valid, 0);
        end
        rd(2'd0, v); check("R10 counter value", v, 905);
        wr(2'd1, 64'd1000);
        wr(2'd0, 64'd997);
        step();
        check("R10 still armed not yet", irq_valid, 0);
        set_host(64'd1203);
        step();
        check("R10 armed fires", irq_valid, 1);
        check("R10 code", irq_vec, 8'h21);
        wr(2'd0, 64'd50);
        rd(2'd0, v); check("R2 floor cleared", v, 50);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset_R3();
        t_count_write_R2();
        t_fire_R4();
        t_clamp_R6();
        t_stale_match_R7();
        t_past_match_R8();
        t_masked_R5();
        t_vec_fields_R11();
        t_cnt_disarm_R10();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule